// File: doc/BRIEF.md
# Queued Single-Outstanding Peripheral Bus Master

This block drains a valid/ready command stream and replays each command as one transfer on a simple peripheral bus. The bus uses a select strobe, a read/write direction flag, an address, write data and per-byte write enables, and the slave answers with separate read and write acknowledge pulses plus an error flag. The master presents one command at a time and holds every bus output frozen until the acknowledge that matches the command's direction arrives.

Every transfer produces exactly one response beat on a valid/ready response port. A read response carries the data sampled on the acknowledge cycle, a write response carries zero data, and both carry the error flag sampled on that same cycle. No new command is accepted until the previous response has been taken, so responses always come back in command order. If the response port is not ready, the master waits.

Top module: `bus_req_master`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_sel` and `rsp_valid` are 0 and `cmd_ready` is 1.
- R2: The cycle after `cmd_valid` and `cmd_ready` are both 1, `bus_sel` is 1 and `bus_rd`, `bus_addr`, `bus_wdata` and `bus_bmask` carry the accepted command's `cmd_read`, `cmd_addr`, `cmd_wdata` and `cmd_bmask`.
- R3: While `bus_sel` is 1 and the acknowledge matching `bus_rd` is 0, the next cycle still has `bus_sel` at 1 with `bus_rd`, `bus_addr`, `bus_wdata` and `bus_bmask` unchanged.
- R4: A read (`bus_rd` = 1) ends only on a cycle where `bus_rack` is 1; `bus_wack` has no effect on it. The next cycle `rsp_valid` is 1 and `rsp_rdata` holds the `bus_rdata` of the acknowledge cycle.
- R5: A write (`bus_rd` = 0) ends only on a cycle where `bus_wack` is 1; `bus_rack` has no effect on it. Its response has `rsp_rdata` equal to 0.
- R6: `rsp_err` equals `bus_err` as sampled on the acknowledge cycle of the same transfer, for reads and for writes.
- R7: `cmd_ready` is 0 while a transfer is on the bus and while a response waits to be taken.
- R8: The cycle after an acknowledge, `bus_sel` is 0; it stays 0 until another command is accepted.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_rdata` and `rsp_err` hold their values.
- R10: Responses come back in the order of the commands, one per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Master can take a command |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | AW | Transfer address |
| cmd_wdata | input | DW | Write data |
| cmd_bmask | input | DW/8 | Write byte enables |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | DW | Read data, 0 for writes |
| rsp_err | output | 1 | Slave error of the transfer |
| bus_sel | output | 1 | Bus select strobe |
| bus_rd | output | 1 | Bus direction, 1 = read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_bmask | output | DW/8 | Bus byte enables |
| bus_rdata | input | DW | Slave read data |
| bus_rack | input | 1 | Slave read acknowledge |
| bus_wack | input | 1 | Slave write acknowledge |
| bus_err | input | 1 | Slave error, valid with an acknowledge |

## Verification
The hardest case to reach is a slave raising the acknowledge of the wrong direction while a transfer waits, because a well-behaved slave never does it. The bench's slave model pulses the opposite acknowledge at random during every wait and drives random read data and error values outside the real acknowledge cycle, so a master that completes on the wrong pulse or samples at the wrong time diverges from the reference model at once. Random acknowledge delays, random gaps in the command stream and random back-pressure on the response port together cover zero-wait transfers, long holds and stalled responses.

// File: rtl/bus_req_master.sv
module bus_req_master #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_read,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [DW-1:0]   cmd_wdata,
  input  logic [DW/8-1:0] cmd_bmask,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_err,
  output logic            bus_sel,
  output logic            bus_rd,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic [DW/8-1:0] bus_bmask,
  input  logic [DW-1:0]   bus_rdata,
  input  logic            bus_rack,
  input  logic            bus_wack,
  input  logic            bus_err
);
  localparam int BW = DW / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_RSP} st_t;
  st_t st;

  logic            rd_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [BW-1:0]   bmask_q;
  logic [DW-1:0]   rdata_q;
  logic            err_q;

  wire take = cmd_valid && cmd_ready;
  wire done = (st == ST_BUS) && (rd_q ? bus_rack : bus_wack);

  assign cmd_ready = (st == ST_IDLE);
  assign bus_sel   = (st == ST_BUS);
  assign rsp_valid = (st == ST_RSP);
  assign bus_rd    = rd_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign bus_bmask = bmask_q;
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      bmask_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (take) begin
          st      <= ST_BUS;
          rd_q    <= cmd_read;
          addr_q  <= cmd_addr;
          wdata_q <= cmd_wdata;
          bmask_q <= cmd_bmask;
        end
        ST_BUS: if (done) begin
          st      <= ST_RSP;
          rdata_q <= rd_q ? bus_rdata : '0;
          err_q   <= bus_err;
        end
        ST_RSP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  wire ack_match = bus_rd ? bus_rack : bus_wack;

  // R2
  accept_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (bus_sel && bus_rd == $past(cmd_read)
      && bus_addr == $past(cmd_addr)));

  // R3
  hold_while_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !ack_match) |=> (bus_sel && $stable(bus_rd) && $stable(bus_addr)
      && $stable(bus_wdata) && $stable(bus_bmask)));

  // R6
  err_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && ack_match) |=> (rsp_valid && rsp_err == $past(bus_err)));

  // R7
  no_take_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel || rsp_valid) |-> !cmd_ready);

  // R8
  sel_drops_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && ack_match) |=> !bus_sel);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
endmodule

// File: tb/bus_req_master_bench.sv
module bus_req_master_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int NCMD = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cmd_valid = 0, cmd_read = 0, rsp_ready = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [BW-1:0] cmd_bmask = '0;
  logic [DW-1:0] bus_rdata = '0;
  logic bus_rack = 0, bus_wack = 0, bus_err = 0;
  logic cmd_ready, rsp_valid, rsp_err, bus_sel, bus_rd;
  logic [DW-1:0] rsp_rdata, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic [BW-1:0] bus_bmask;

  bus_req_master #(.AW(AW), .DW(DW)) u_bus_req_master (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_bmask(cmd_bmask),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_bmask(bus_bmask), .bus_rdata(bus_rdata), .bus_rack(bus_rack),
    .bus_wack(bus_wack), .bus_err(bus_err)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model state: 0 idle, 1 on bus, 2 response pending
  int m_st = 0;
  logic m_rd;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wd, m_rdata;
  logic [BW-1:0] m_bm;
  logic m_err;
  logic [DW-1:0] shadow [16];
  logic [DW-1:0] smem [16];
  logic [DW-1:0] exp_q [$];
  int issued = 0, answered = 0;
  bit took = 0;
  int wait_cnt = 0;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [BW-1:0] bm);
    logic [DW-1:0] r = old;
    for (int b = 0; b < BW; b++) if (bm[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  always @(posedge clk) if (rst_n) begin
    if (bus_sel && bus_wack && !bus_rd)
      smem[bus_addr[5:2]] <= merge(smem[bus_addr[5:2]], bus_wdata, bus_bmask);
    case (m_st)
      0: if (cmd_valid) begin
        m_st = 1; m_rd = cmd_read; m_addr = cmd_addr; m_wd = cmd_wdata; m_bm = cmd_bmask;
        took = 1; issued++;
        if (cmd_read) exp_q.push_back(shadow[cmd_addr[5:2]]);
        else begin
          exp_q.push_back('0);
          shadow[cmd_addr[5:2]] = merge(shadow[cmd_addr[5:2]], cmd_wdata, cmd_bmask);
        end
      end
      1: if (m_rd ? bus_rack : bus_wack) begin
        m_st = 2; m_rdata = m_rd ? bus_rdata : '0; m_err = bus_err;
      end
      2: if (rsp_ready) begin
        m_st = 0; answered++;
        void'(exp_q.pop_front());
      end
      default: m_st = 0;
    endcase
  end

  always @(negedge clk) if (rst_n) begin
    chk(cmd_ready == (m_st == 0), "R7 cmd_ready", cmd_ready, m_st == 0);
    chk(bus_sel == (m_st == 1), "R8 bus_sel", bus_sel, m_st == 1);
    chk(rsp_valid == (m_st == 2), "R9 rsp_valid", rsp_valid, m_st == 2);
    if (m_st == 1) begin
      chk(bus_rd == m_rd, "R2 bus_rd", bus_rd, m_rd);
      chk(bus_addr == m_addr, "R3 bus_addr", bus_addr, m_addr);
      if (!m_rd) begin
        chk(bus_wdata == m_wd, "R3 bus_wdata", bus_wdata, m_wd);
        chk(bus_bmask == m_bm, "R2 bus_bmask", bus_bmask, m_bm);
      end
    end
    if (m_st == 2) begin
      chk(rsp_rdata == m_rdata, m_rd ? "R4 rsp_rdata" : "R5 rsp_rdata", rsp_rdata, m_rdata);
      chk(rsp_err == m_err, "R6 rsp_err", rsp_err, m_err);
      if (exp_q.size() > 0)
        chk(rsp_rdata == exp_q[0], "R10 ordered data", rsp_rdata, exp_q[0]);
    end
    // slave model: random delay, spurious opposite acknowledge, random noise
    bus_rdata = $urandom;
    bus_err = ($urandom % 5) == 0;
    bus_rack = 0; bus_wack = 0;
    if (!bus_sel) wait_cnt = $urandom % 5;
    else if (wait_cnt == 0) begin
      if (bus_rd) begin bus_rack = 1; bus_rdata = smem[bus_addr[5:2]]; end
      else bus_wack = 1;
    end else begin
      wait_cnt--;
      if ($urandom % 2) begin
        if (bus_rd) bus_wack = 1; else bus_rack = 1;
      end
    end
    // command source
    if (!cmd_valid || took) begin
      took = 0;
      if (issued < NCMD && ($urandom % 3) != 0) begin
        cmd_valid = 1; cmd_read = $urandom % 2; cmd_addr = $urandom;
        cmd_wdata = $urandom; cmd_bmask = $urandom;
      end else cmd_valid = 0;
    end
    rsp_ready = ($urandom % 3) != 0;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin shadow[i] = '0; smem[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!bus_sel && !rsp_valid && cmd_ready, "R1 reset outputs",
        {bus_sel, rsp_valid, cmd_ready}, 3'b001);
    rst_n = 1;
    @(posedge clk);
    #1;
    // R1 first cycle after reset
    chk(!bus_sel && !rsp_valid && cmd_ready, "R1 after reset",
        {bus_sel, rsp_valid, cmd_ready}, 3'b001);
  end

  initial begin
    int cyc = 0;
    while (answered < NCMD && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (answered < NCMD) begin
      checks++; fails++;
      $display("FAIL R10 watchdog answered=%0d expected=%0d", answered, NCMD);
    end
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule